// File: doc/BRIEF.md
# Hybrid Two-Tier Virtual-Channel Input Buffer

This block is the flit store for one virtual channel at a router input port. Arriving flits first land in a small front-end store with single-cycle access. Under a lazy policy, they may then be moved into a larger back-end store, whose writes take several cycles before the entry can be read. The amount of front-end occupancy that triggers a move is set at run time. A threshold of zero moves every flit, which is simple migration. Higher thresholds keep flits in the fast tier while load is light, which saves back-end write energy.

Flits leave toward the crossbar strictly in arrival order, always taking the oldest flit held in either tier. Upstream flow control counts only front-end slots. A credit pulse is returned each time a front-end slot is freed, whether its flit departed or migrated. A port wrapper places one instance per virtual channel.

Top module: `hybrid_vc_buffer`

## Requirements
- R1: Flits leave in exactly the order they arrived, across both tiers. `out_flit` is the oldest flit held whenever `out_valid` is 1, and it departs on a cycle where `out_valid` and `out_ready` are both 1.
- R2: A flit arriving in cycle t into an empty buffer, with no migration, is presented on the output in cycle t+1.
- R3: A flit migrated in cycle m cannot be read before cycle m+BE_WR_LAT. While the oldest flit is still being written, `out_valid` is 0, even if younger flits wait in the front-end.
- R4: A flit is migrated only when front-end occupancy in flits is at least `mig_thresh` and non-zero. For a 4-entry front-end, thresholds 0, 1, 2 and 3 mean 0%, 25%, 50% and 75%. Below the threshold, flits stay in the front-end.
- R5: With `mig_thresh` = 0, every flit not read at once moves on in the cycle after arrival, and the buffer sustains one arrival and one departure per cycle.
- R6: Migration is withheld while the back-end holds BE_DEPTH entries, including entries whose write is still in flight.
- R7: If the oldest front-end flit is read in the same cycle it could migrate, the read wins. At most one front-end slot is freed per cycle.
- R8: `credit_out` is a one-cycle pulse in the cycle after a front-end slot is freed, by departure or by migration. Otherwise it stays 0.
- R9: After reset the buffer is empty: `out_valid` = 0 and `credit_out` = 0.
- R10: With an upstream sender that starts at FE_DEPTH credits, spends one per flit and regains one per `credit_out` pulse, the sender's credit count equals the free front-end slots. The front-end never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Flit arrives from the link this cycle |
| in_flit | input | FLIT_W | Arriving flit |
| mig_thresh | input | $clog2(FE_DEPTH) | Front-end occupancy, in flits, at which migration starts |
| out_ready | input | 1 | Crossbar takes the presented flit |
| out_valid | output | 1 | A readable oldest flit is presented |
| out_flit | output | FLIT_W | Oldest flit |
| credit_out | output | 1 | One front-end slot was freed in the previous cycle |

## Verification
On every cycle, the assertions check three things. They check that the occupancy of each tier stays within its depth. They check that each credit pulse matches a one-slot drop in front-end occupancy, and that no more than one slot frees per cycle. They check that the back-end grows only when front-end occupancy was at or above the threshold. Arrival order, the hidden write latency of migrated flits, the read-over-migration priority and sustained throughput only show up in the bench's scenarios. These scenarios compare every output cycle against a queue model while sweeping thresholds, filling the back-end and streaming traffic.

// File: rtl/hvb_pkg.sv
package hvb_pkg;
  // Which tier supplies the oldest flit
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FE   = 2'd1,
    SRC_BE   = 2'd2
  } head_src_e;
endpackage

// File: rtl/hvb_fast_store.sv
module hvb_fast_store #(
  parameter int W     = 128,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head_data,
  output logic [CW-1:0] count
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];
endmodule

// File: rtl/hvb_slow_store.sv
module hvb_slow_store #(
  parameter int W     = 128,
  parameter int DEPTH = 8,
  parameter int LAT   = 6,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head_data,
  output logic          head_ready,
  output logic [CW-1:0] count
);
  localparam int PW = $clog2(DEPTH);
  localparam int BW = $clog2(LAT + 1);
  localparam logic [BW-1:0] BUSY_INIT = BW'(LAT - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [DEPTH-1:0] idle;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  // One write-latency counter per entry; writes pipeline across entries
  for (genvar i = 0; i < DEPTH; i++) begin : g_busy
    logic [BW-1:0] busy_q;
    always_ff @(posedge clk) begin
      if (rst)
        busy_q <= '0;
      else if (push && wr_ptr == PW'(i))
        busy_q <= BUSY_INIT;
      else if (busy_q != '0)
        busy_q <= busy_q - 1'b1;
    end
    assign idle[i] = (busy_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_data  = mem[rd_ptr];
  assign head_ready = idle[rd_ptr];
endmodule

// File: rtl/hvb_mig_ctrl.sv
module hvb_mig_ctrl
  import hvb_pkg::*;
#(
  parameter int FE_DEPTH = 4,
  parameter int BE_DEPTH = 8,
  parameter int FE_CW    = $clog2(FE_DEPTH + 1),
  parameter int BE_CW    = $clog2(BE_DEPTH + 1),
  parameter int THR_W    = $clog2(FE_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FE_CW-1:0] fe_cnt,
  input  logic [BE_CW-1:0] be_cnt,
  input  logic [THR_W-1:0] thresh,
  input  logic             be_head_ready,
  input  logic             out_ready,
  output head_src_e        src,
  output logic             out_valid,
  output logic             fe_pop,
  output logic             be_pop,
  output logic             mig_go,
  output logic             credit_out
);
  logic above_thr, be_room;

  // Every back-end flit is older than every front-end flit
  always_comb begin
    if (be_cnt != '0)      src = SRC_BE;
    else if (fe_cnt != '0) src = SRC_FE;
    else                   src = SRC_NONE;
  end

  assign out_valid = (src == SRC_FE) || (src == SRC_BE && be_head_ready);
  assign fe_pop    = out_ready && (src == SRC_FE);
  assign be_pop    = out_ready && out_valid && (src == SRC_BE);

  assign above_thr = (fe_cnt != '0) && (int'(fe_cnt) >= int'(thresh));
  assign be_room   = int'(be_cnt) < BE_DEPTH;
  // A read of the front-end head pre-empts its migration
  assign mig_go    = above_thr && be_room && !fe_pop;

  always_ff @(posedge clk) begin
    if (rst) credit_out <= 1'b0;
    else     credit_out <= fe_pop || mig_go;
  end
endmodule

// File: rtl/hybrid_vc_buffer.sv
module hybrid_vc_buffer
  import hvb_pkg::*;
#(
  parameter int FLIT_W    = 128,
  parameter int FE_DEPTH  = 4,
  parameter int BE_DEPTH  = 8,
  parameter int BE_WR_LAT = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [FLIT_W-1:0]           in_flit,
  input  logic [$clog2(FE_DEPTH)-1:0] mig_thresh,
  input  logic                        out_ready,
  output logic                        out_valid,
  output logic [FLIT_W-1:0]           out_flit,
  output logic                        credit_out
);
  localparam int FE_CW = $clog2(FE_DEPTH + 1);
  localparam int BE_CW = $clog2(BE_DEPTH + 1);
  localparam int THR_W = $clog2(FE_DEPTH);

  logic [FE_CW-1:0]  fe_cnt;
  logic [BE_CW-1:0]  be_cnt;
  logic [FLIT_W-1:0] fe_head, be_head;
  logic              be_head_ready, fe_pop, be_pop, mig_go;
  head_src_e         src;

  hvb_fast_store #(.W(FLIT_W), .DEPTH(FE_DEPTH), .CW(FE_CW)) u_fast (
    .clk(clk), .rst(rst),
    .push(in_valid), .push_data(in_flit),
    .pop(fe_pop || mig_go),
    .head_data(fe_head), .count(fe_cnt)
  );

  hvb_slow_store #(.W(FLIT_W), .DEPTH(BE_DEPTH), .LAT(BE_WR_LAT), .CW(BE_CW)) u_slow (
    .clk(clk), .rst(rst),
    .push(mig_go), .push_data(fe_head),
    .pop(be_pop),
    .head_data(be_head), .head_ready(be_head_ready), .count(be_cnt)
  );

  hvb_mig_ctrl #(
    .FE_DEPTH(FE_DEPTH), .BE_DEPTH(BE_DEPTH),
    .FE_CW(FE_CW), .BE_CW(BE_CW), .THR_W(THR_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .fe_cnt(fe_cnt), .be_cnt(be_cnt), .thresh(mig_thresh),
    .be_head_ready(be_head_ready), .out_ready(out_ready),
    .src(src), .out_valid(out_valid),
    .fe_pop(fe_pop), .be_pop(be_pop), .mig_go(mig_go),
    .credit_out(credit_out)
  );

  assign out_flit = (src == SRC_BE) ? be_head : fe_head;
endmodule

// File: rtl/hybrid_vc_buffer_chk.sv
module hybrid_vc_buffer_chk #(
  parameter int FE_DEPTH = 4,
  parameter int BE_DEPTH = 8,
  parameter int THR_W    = 2,
  parameter int FE_CW    = 3,
  parameter int BE_CW    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [THR_W-1:0] mig_thresh,
  input logic             out_valid,
  input logic             credit_out,
  input logic [FE_CW-1:0] fe_cnt,
  input logic [BE_CW-1:0] be_cnt
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R9
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (!out_valid && !credit_out));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    int'(fe_cnt) <= FE_DEPTH);

  // R6
  be_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(be_cnt) <= BE_DEPTH);

  // R8
  credit_match_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    credit_out == (int'(fe_cnt) != int'($past(fe_cnt)) + int'($past(in_valid))));

  // R7
  single_free_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    int'(fe_cnt) + 1 >= int'($past(fe_cnt)));

  // R4
  lazy_mig_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (int'(be_cnt) > int'($past(be_cnt))) |->
      ($past(fe_cnt) != '0 && int'($past(fe_cnt)) >= int'($past(mig_thresh))));
endmodule

bind hybrid_vc_buffer hybrid_vc_buffer_chk #(
  .FE_DEPTH(FE_DEPTH), .BE_DEPTH(BE_DEPTH),
  .THR_W(THR_W), .FE_CW(FE_CW), .BE_CW(BE_CW)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .mig_thresh(mig_thresh),
  .out_valid(out_valid), .credit_out(credit_out),
  .fe_cnt(fe_cnt), .be_cnt(be_cnt)
);

// File: tb/hybrid_vc_buffer_test.sv
module hybrid_vc_buffer_test;
  localparam int FW  = 128;
  localparam int FE  = 4;
  localparam int BE  = 8;
  localparam int LAT = 6;
  localparam int TW  = $clog2(FE);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [FW-1:0] in_flit = '0;
  logic [TW-1:0] mig_thresh = '0;
  logic          out_ready = 1'b0;
  logic          out_valid;
  logic [FW-1:0] out_flit;
  logic          credit_out;

  always #10 clk = ~clk;

  hybrid_vc_buffer #(.FLIT_W(FW), .FE_DEPTH(FE), .BE_DEPTH(BE), .BE_WR_LAT(LAT)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit),
    .mig_thresh(mig_thresh), .out_ready(out_ready),
    .out_valid(out_valid), .out_flit(out_flit), .credit_out(credit_out)
  );

  // Behavioural reference
  logic [FW-1:0] fe_q[$];
  logic [FW-1:0] be_q[$];
  int            be_rdy[$];
  int            cyc = 0, credits = FE, checks = 0, fails = 0, departs = 0;
  int            thr = 0;
  bit            cred_pend = 0;
  bit            finished = 0;

  task automatic chk(input bit ok, input string req, input logic [FW-1:0] act,
                     input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input bit want_in, input bit rd);
    bit            exp_v, pop, from_fe, mig;
    logic [FW-1:0] exp_d;
    @(negedge clk);
    exp_v = (be_q.size() > 0) ? (be_rdy[0] <= cyc) : (fe_q.size() > 0);
    exp_d = (be_q.size() > 0) ? be_q[0] : ((fe_q.size() > 0) ? fe_q[0] : '0);
    chk(out_valid == exp_v, "R3 out_valid", FW'(out_valid), FW'(exp_v));
    if (exp_v && out_valid) chk(out_flit == exp_d, "R1 order", out_flit, exp_d);
    chk(credit_out == cred_pend, "R8 credit", FW'(credit_out), FW'(cred_pend));
    if (credit_out) credits++;
    chk(credits == FE - fe_q.size(), "R10 credits", FW'(credits), FW'(FE - fe_q.size()));
    mig_thresh = TW'(thr);
    in_valid   = want_in && (credits > 0);
    in_flit    = {$urandom, $urandom, $urandom, $urandom};
    out_ready  = rd;
    if (in_valid) credits--;
    pop     = exp_v && rd;
    from_fe = pop && (be_q.size() == 0);
    mig     = (fe_q.size() > 0) && (fe_q.size() >= thr) && (be_q.size() < BE) && !from_fe;
    if (pop) begin
      departs++;
      if (be_q.size() > 0) begin
        void'(be_q.pop_front());
        void'(be_rdy.pop_front());
      end else void'(fe_q.pop_front());
    end
    if (mig) begin
      be_q.push_back(fe_q.pop_front());
      be_rdy.push_back(cyc + LAT);
    end
    if (in_valid) fe_q.push_back(in_flit);
    cred_pend = from_fe || mig;
    cyc++;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && (fe_q.size() + be_q.size()) > 0; i++) step(0, 1);
    step(0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk(out_valid == 1'b0, "R9 out_valid", FW'(out_valid), '0);
    chk(credit_out == 1'b0, "R9 credit_out", FW'(credit_out), '0);

    // R2: single flit, threshold 50%, stays in front-end and is visible next cycle
    thr = 2;
    step(1, 0);
    step(0, 0);
    chk(credits == FE - 1, "R4 no migration below threshold", FW'(credits), FW'(FE - 1));
    repeat (8) step(0, 0);
    chk(credits == FE - 1, "R4 still held", FW'(credits), FW'(FE - 1));
    drain();

    // R4: threshold 75%, fill front-end; two flits move, two stay
    thr = 3;
    repeat (4) step(1, 0);
    repeat (12) step(0, 0);
    chk(credits == 2, "R4 lazy fill", FW'(credits), FW'(2));
    drain();

    // R6: simple migration, no reads; back-end fills, then credits run out
    thr = 0;
    repeat (24) step(1, 0);
    repeat (LAT + 2) step(0, 0);
    chk(credits == 0, "R6 back-end full", FW'(credits), '0);
    drain();

    // R5/R7: simple migration streaming, one in and one out per cycle
    thr = 0;
    departs = 0;
    repeat (40) step(1, 1);
    chk(departs >= 40 - LAT - 3, "R5 throughput", FW'(departs), FW'(40 - LAT - 3));
    drain();

    // R5: stalled reads force migration, then resume
    repeat (6) step(1, 0);
    repeat (30) step(1, 1);
    drain();

    // Threshold sweep with random traffic
    for (int t = 0; t < FE; t++) begin
      thr = t;
      for (int k = 0; k < 300; k++) step(($urandom % 3) != 0, ($urandom % 2) == 0);
      drain();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule